// File: doc/BRIEF.md
# Text-Mode Video Timing and Character Fetch Engine

This block produces the raster timing for a 640×480 display from a 50 MHz clock. It also fetches everything needed to paint an 80-column by 30-row character screen. Each 16-clock character slot on an active line reads three bytes from external static RAM: the character code, its attribute byte and its colour byte. The code and the font field of the attribute then address an external glyph ROM. The glyph row for that cell comes back one slot later. One slot after that, the glyph, colour and attribute appear together on the output registers, where a downstream pixel shader consumes them.

The fetch chain is two character slots deep. To keep the picture aligned, horizontal blanking and horizontal sync are moved two slots (640 ns) later than the usual 640×480 placement, and the line's back porch is shortened by the same amount. The RAM bus is owned by the block only on active lines. During vertical blanking the block drops `busy` and holds the RAM address at zero, so the host may use the RAM. Holding `rst_n` low stops all video output and releases the RAM bus at once. The block has no write port, so RAM contents are never touched.

Top module: `vtx_text_engine`

## Requirements
- R1: Position 0 of line 0 is the first clock after the first rising edge that samples `rst_n` high. A line lasts 1600 clocks and holds 100 slots of 16 clocks each. `hsync_n` is low exactly on line positions 1344 to 1535, which is 192 clocks.
- R2: The line counter advances when a line wraps. It counts V_ACTIVE+V_FP+V_SYNC+V_BP lines per frame (480+10+2+33 = 525 by default) and then returns to 0. `vsync_n` is low exactly on lines V_ACTIVE+V_FP and V_ACTIVE+V_FP+1 (490 and 491 by default).
- R3: `blank` is 0 only on line positions 32 to 1311 of lines below V_ACTIVE. This is the standard active window moved two slots later.
- R4: `busy` is 1 on lines below V_ACTIVE and 0 on the vertical blanking lines. While `busy` is 0, `ram_addr` is 0.
- R5: While `busy` is 1, `ram_addr` is {page[1:0], line[8:4], slot[6:0]}, where slot is the line position divided by 16. The page is 0 (character code) for slot phases 0-3, 1 (attribute) for phases 4-7 and 2 (colour) for phases 8-15. `ram_rdata` is captured at the end of phases 3, 7 and 11.
- R6: In slot k ≥ 1 of an active line, `rom_addr` is {attribute[7:3], code[7:0], line[3:0]} for the cell fetched in slot k-1. `rom_rdata` is captured at the end of phase 7. While `busy` is 0, `rom_addr` is 0.
- R7: Wherever `blank` is 0 in slot k, `glyph`, `color` and `attr` hold the glyph row, colour byte and attribute byte of column k-2 of the current text row.
- R8: During reset and on the first cycle after it, `hsync_n` and `vsync_n` are 1, `blank` is 1, `busy` is 0, both address buses are 0 and `glyph`, `color` and `attr` are 0. A reset mid-frame restarts the raster at position 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock, 50 MHz nominal |
| rst_n | input | 1 | Synchronous active-low reset; stops video and frees the RAM bus |
| ram_addr | output | 14 | Screen RAM address {page, text row, column} |
| ram_rdata | input | 8 | Screen RAM read data |
| busy | output | 1 | 1 while the block owns the RAM bus (active lines) |
| rom_addr | output | 17 | Glyph ROM address {font, code, glyph row} |
| rom_rdata | input | 8 | Glyph ROM read data |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | 1 outside the displayed area |
| glyph | output | 8 | Glyph row of the cell being displayed |
| color | output | 8 | Colour byte of the cell being displayed |
| attr | output | 8 | Attribute byte of the cell being displayed |

## Verification
The assertions assume that the RAM and ROM answer within their capture windows: four clocks after a RAM address change, and eight clocks after a ROM address change. They also assume that reset is held for at least one full clock. The bench meets the first assumption with combinational memory models. Their contents come from a hash of the address and a seed drawn from `$urandom`, so every cell carries a different code, font and colour. The bench also holds each reset, including one applied at a random point mid-line, for several cycles.

// File: rtl/vtx_pkg.sv
// Package vtx_pkg
// Shared widths and types for the text-mode video engine. The counter and bus
// widths are fixed by the address layout that the memories decode.
package vtx_pkg;
    localparam int HCNT_W = 11;            // line position counter
    localparam int VCNT_W = 10;            // line counter
    localparam int PH_W   = 4;             // clock phase within a character slot
    localparam int COL_W  = 7;             // character column field
    localparam int TROW_W = 5;             // text row field
    localparam int GROW_W = 4;             // glyph row field
    localparam int PAGE_W = 2;             // RAM page field
    localparam int FONT_W = 5;             // font field of the attribute
    localparam int DATA_W = 8;
    localparam int RAM_AW = PAGE_W + TROW_W + COL_W;
    localparam int ROM_AW = FONT_W + DATA_W + GROW_W;
    localparam int SLOT_CLKS = 1 << PH_W;
    localparam int SUB_CLKS  = SLOT_CLKS / 4;  // clocks per RAM sub-access

    typedef enum logic [PAGE_W-1:0] {
        PG_CODE  = 2'd0,
        PG_ATTR  = 2'd1,
        PG_COLOR = 2'd2
    } page_e;

    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic [DATA_W-1:0] attr;
        logic [DATA_W-1:0] color;
    } cell_t;
endpackage

// File: rtl/vtx_timing.sv
// Module vtx_timing
// Raster counters and the sync, blank and bus-ownership flags. The line position
// counts clocks; the low PH_W bits are the phase inside a character slot.
// Assumes the horizontal total fits HCNT_W bits, the frame fits VCNT_W bits,
// and PIPE_CH does not exceed H_BP_CH (the shift is taken from the back porch).
module vtx_timing
    import vtx_pkg::*;
#(
    parameter int H_ACTIVE_CH = 80,
    parameter int H_FP_CH     = 2,
    parameter int H_SYNC_CH   = 12,
    parameter int H_BP_CH     = 6,
    parameter int PIPE_CH     = 2,
    parameter int V_ACTIVE    = 480,
    parameter int V_FP        = 10,
    parameter int V_SYNC      = 2,
    parameter int V_BP        = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              run,
    output logic [PH_W-1:0]   phase,
    output logic [COL_W-1:0]  col,
    output logic [TROW_W-1:0] trow,
    output logic [GROW_W-1:0] grow,
    output logic              hs_n,
    output logic              vs_n,
    output logic              blank,
    output logic              busy
);
    localparam int H_TOTAL  = (H_ACTIVE_CH + H_FP_CH + H_SYNC_CH + H_BP_CH) * SLOT_CLKS;
    localparam int HB_END   = PIPE_CH * SLOT_CLKS;
    localparam int HB_START = (PIPE_CH + H_ACTIVE_CH) * SLOT_CLKS;
    localparam int HS_START = HB_START + H_FP_CH * SLOT_CLKS;
    localparam int HS_END   = HS_START + H_SYNC_CH * SLOT_CLKS;
    localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int VS_START = V_ACTIVE + V_FP;
    localparam int VS_END   = VS_START + V_SYNC;

    logic [HCNT_W-1:0] hcnt;
    logic [VCNT_W-1:0] vcnt;
    logic              hwrap;
    logic              vwrap;
    logic              h_disp;
    logic              h_sync;
    logic              v_disp;
    logic              v_sync;

    assign hwrap = (hcnt == HCNT_W'(H_TOTAL - 1));
    assign vwrap = (vcnt == VCNT_W'(V_TOTAL - 1));

    // Purpose: advance the raster position once the engine is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            hcnt <= '0;
            vcnt <= '0;
        end else begin
            run <= 1'b1;
            if (run) begin
                if (hwrap) begin
                    hcnt <= '0;
                    vcnt <= vwrap ? '0 : vcnt + 1'b1;
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    // Purpose: decode the horizontal and vertical windows from the counters.
    always_comb begin
        h_disp = (hcnt >= HCNT_W'(HB_END)) && (hcnt < HCNT_W'(HB_START));
        h_sync = (hcnt >= HCNT_W'(HS_START)) && (hcnt < HCNT_W'(HS_END));
        v_disp = (vcnt < VCNT_W'(V_ACTIVE));
        v_sync = (vcnt >= VCNT_W'(VS_START)) && (vcnt < VCNT_W'(VS_END));
    end

    // Purpose: drive the video flags, all held inactive while stopped.
    always_comb begin
        hs_n  = !(run && h_sync);
        vs_n  = !(run && v_sync);
        blank = !(run && h_disp && v_disp);
        busy  = run && v_disp;
    end

    assign phase = hcnt[PH_W-1:0];
    assign col   = hcnt[PH_W +: COL_W];
    assign grow  = vcnt[GROW_W-1:0];
    assign trow  = vcnt[GROW_W +: TROW_W];
endmodule

// File: rtl/vtx_fetch.sv
// Module vtx_fetch
// Two-slot fetch chain. Slot k reads code, attribute and colour of column k from
// the RAM. Slot k+1 reads the glyph row from the ROM. The end of slot k+1 loads
// the output registers. Assumes RAM data is valid SUB_CLKS-1 clocks after an
// address change and ROM data within half a slot.
module vtx_fetch
    import vtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic [PH_W-1:0]   phase,
    input  logic [COL_W-1:0]  col,
    input  logic [TROW_W-1:0] trow,
    input  logic [GROW_W-1:0] grow,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [DATA_W-1:0] glyph,
    output logic [DATA_W-1:0] color,
    output logic [DATA_W-1:0] attr
);
    localparam logic [PH_W-1:0] PH_CODE  = PH_W'(SUB_CLKS - 1);
    localparam logic [PH_W-1:0] PH_ATTR  = PH_W'(2 * SUB_CLKS - 1);
    localparam logic [PH_W-1:0] PH_COLOR = PH_W'(3 * SUB_CLKS - 1);
    localparam logic [PH_W-1:0] PH_GLYPH = PH_W'(SLOT_CLKS / 2 - 1);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(SLOT_CLKS - 1);

    page_e             page;
    cell_t             stage1;     // bytes of the cell read in this slot
    cell_t             stage2;     // bytes of the cell read in the previous slot
    logic [DATA_W-1:0] glyph_tmp;

    // Purpose: choose the RAM page from the sub-access the phase is in.
    always_comb begin
        unique case (phase[PH_W-1 -: 2])
            2'd0:    page = PG_CODE;
            2'd1:    page = PG_ATTR;
            default: page = PG_COLOR;
        endcase
    end

    // Purpose: drive the memory addresses, parked at zero when the bus is free.
    always_comb begin
        if (fetch_en) begin
            ram_addr = {page, trow, col};
            rom_addr = {stage2.attr[DATA_W-1 -: FONT_W], stage2.code, grow};
        end else begin
            ram_addr = '0;
            rom_addr = '0;
        end
    end

    // Purpose: capture each RAM byte at the end of its sub-access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
        end else if (fetch_en) begin
            if (phase == PH_CODE)  stage1.code  <= ram_rdata;
            if (phase == PH_ATTR)  stage1.attr  <= ram_rdata;
            if (phase == PH_COLOR) stage1.color <= ram_rdata;
        end
    end

    // Purpose: hand the fetched cell to the ROM stage at the slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage2 <= '0;
        end else if (fetch_en && phase == PH_LAST) begin
            stage2 <= stage1;
        end
    end

    // Purpose: hold the glyph row returned by the ROM until the slot ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glyph_tmp <= '0;
        end else if (fetch_en && phase == PH_GLYPH) begin
            glyph_tmp <= rom_rdata;
        end
    end

    // Purpose: load glyph, colour and attribute together for display.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glyph <= '0;
            color <= '0;
            attr  <= '0;
        end else if (fetch_en && phase == PH_LAST) begin
            glyph <= glyph_tmp;
            color <= stage2.color;
            attr  <= stage2.attr;
        end
    end
endmodule

// File: rtl/vtx_text_engine.sv
// Module vtx_text_engine
// Top level of the text-mode video engine: raster timing plus the two-slot
// character fetch chain. Blanking and sync are placed PIPE_CH slots late so the
// output registers line up with the displayed cell. Assumes asynchronous-read
// memories on both buses.
module vtx_text_engine
    import vtx_pkg::*;
#(
    parameter int H_ACTIVE_CH = 80,
    parameter int H_FP_CH     = 2,
    parameter int H_SYNC_CH   = 12,
    parameter int H_BP_CH     = 6,
    parameter int PIPE_CH     = 2,
    parameter int V_ACTIVE    = 480,
    parameter int V_FP        = 10,
    parameter int V_SYNC      = 2,
    parameter int V_BP        = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [RAM_AW-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              busy,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              blank,
    output logic [DATA_W-1:0] glyph,
    output logic [DATA_W-1:0] color,
    output logic [DATA_W-1:0] attr
);
    logic              run;
    logic [PH_W-1:0]   phase;
    logic [COL_W-1:0]  col;
    logic [TROW_W-1:0] trow;
    logic [GROW_W-1:0] grow;
    logic              own_bus;

    vtx_timing #(
        .H_ACTIVE_CH (H_ACTIVE_CH),
        .H_FP_CH     (H_FP_CH),
        .H_SYNC_CH   (H_SYNC_CH),
        .H_BP_CH     (H_BP_CH),
        .PIPE_CH     (PIPE_CH),
        .V_ACTIVE    (V_ACTIVE),
        .V_FP        (V_FP),
        .V_SYNC      (V_SYNC),
        .V_BP        (V_BP)
    ) u_timing (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .phase (phase),
        .col   (col),
        .trow  (trow),
        .grow  (grow),
        .hs_n  (hsync_n),
        .vs_n  (vsync_n),
        .blank (blank),
        .busy  (own_bus)
    );

    vtx_fetch u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_en  (own_bus && run),
        .phase     (phase),
        .col       (col),
        .trow      (trow),
        .grow      (grow),
        .ram_rdata (ram_rdata),
        .rom_rdata (rom_rdata),
        .ram_addr  (ram_addr),
        .rom_addr  (rom_addr),
        .glyph     (glyph),
        .color     (color),
        .attr      (attr)
    );

    assign busy = own_bus;
endmodule

// File: rtl/vtx_text_engine_chk.sv
// Module vtx_text_engine_chk
// Port-level properties of the text engine, bound into every instance.
// Assumes reset is held for at least one clock.
module vtx_text_engine_chk #(
    parameter int HS_CLKS = 192
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hsync_n,
    input logic        vsync_n,
    input logic        blank,
    input logic        busy,
    input logic [13:0] ram_addr,
    input logic [16:0] rom_addr,
    input logic [7:0]  glyph
);
    logic [15:0] hs_len;

    // Purpose: measure the current low run of horizontal sync.
    always_ff @(posedge clk) begin
        if (!rst_n)        hs_len <= '0;
        else if (!hsync_n) hs_len <= hs_len + 1'b1;
        else               hs_len <= '0;
    end

    p_hs_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (hs_len == 16'(HS_CLKS)));

    p_vs_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> (blank && !busy));

    p_idle_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> blank);

    p_idle_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ram_addr == 14'd0));

    p_page_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ram_addr[13:12] != 2'd3));

    p_idle_rom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rom_addr == 17'd0));

    p_glyph_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(glyph)) |-> !$stable(ram_addr[6:0]));

    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |=> (hsync_n && vsync_n && blank && !busy && glyph == 8'd0));
endmodule

bind vtx_text_engine vtx_text_engine_chk #(.HS_CLKS(H_SYNC_CH * 16)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .blank    (blank),
    .busy     (busy),
    .ram_addr (ram_addr),
    .rom_addr (rom_addr),
    .glyph    (glyph)
);

// File: tb/vtx_text_engine_tb.sv
// Bench for vtx_text_engine: a shortened frame (vertical parameters reduced),
// hashed memory contents from a seeded $urandom, a full frame wrap and a reset
// at a random point mid-line. Every cycle is compared with a model of the
// requirements.
module vtx_text_engine_tb;
    localparam int VA = 32;
    localparam int VF = 10;
    localparam int VS = 2;
    localparam int VB = 4;
    localparam int VT = VA + VF + VS + VB;
    localparam int HT = 1600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ram_addr;
    logic [7:0]  ram_rdata;
    logic        busy;
    logic [16:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic        hsync_n;
    logic        vsync_n;
    logic        blank;
    logic [7:0]  glyph;
    logic [7:0]  color;
    logic [7:0]  attr;
    logic [7:0]  mseed = 8'h00;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] ram_f(input logic [13:0] a, input logic [7:0] s);
        logic [31:0] x;
        x = {18'd0, a} * 32'd2654435761;
        return x[23:16] ^ s;
    endfunction

    function automatic logic [7:0] rom_f(input logic [16:0] a, input logic [7:0] s);
        logic [31:0] x;
        x = {15'd0, a} * 32'd2246822519;
        return x[24:17] ^ ~s;
    endfunction

    assign ram_rdata = ram_f(ram_addr, mseed);
    assign rom_rdata = rom_f(rom_addr, mseed);

    vtx_text_engine #(
        .V_ACTIVE (VA),
        .V_FP     (VF),
        .V_SYNC   (VS),
        .V_BP     (VB)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ram_addr  (ram_addr),
        .ram_rdata (ram_rdata),
        .busy      (busy),
        .rom_addr  (rom_addr),
        .rom_rdata (rom_rdata),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n),
        .blank     (blank),
        .glyph     (glyph),
        .color     (color),
        .attr      (attr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_cycle();
        logic [31:0] t, h, v, k, ph, c;
        logic [1:0]  pg;
        logic [7:0]  e_code, e_attr, e_color;
        logic        e_blank;
        if (edges == 0) begin
            chk("R8 hsync_n", 32'(hsync_n), 32'd1);
            chk("R8 vsync_n", 32'(vsync_n), 32'd1);
            chk("R8 blank", 32'(blank), 32'd1);
            chk("R8 busy", 32'(busy), 32'd0);
            chk("R8 ram_addr", 32'(ram_addr), 32'd0);
            chk("R8 rom_addr", 32'(rom_addr), 32'd0);
            chk("R8 outputs", {8'd0, glyph, color, attr}, 32'd0);
            return;
        end
        t  = 32'(edges - 1);
        h  = t % HT;
        v  = (t / HT) % VT;
        k  = h / 16;
        ph = h % 16;
        e_blank = (h < 32) || (h >= 1312) || (v >= VA);
        chk("R1 hsync_n", 32'(hsync_n), 32'(!(h >= 1344 && h < 1536)));
        chk("R2 vsync_n", 32'(vsync_n), 32'(!(v >= VA + VF && v < VA + VF + VS)));
        chk("R3 blank", 32'(blank), 32'(e_blank));
        chk("R4 busy", 32'(busy), 32'(v < VA));
        if (v < VA) begin
            pg = (ph < 4) ? 2'd0 : (ph < 8) ? 2'd1 : 2'd2;
            chk("R5 ram_addr", 32'(ram_addr), 32'({pg, v[8:4], k[6:0]}));
            if (k >= 1) begin
                c = k - 1;
                e_code = ram_f({2'd0, v[8:4], c[6:0]}, mseed);
                e_attr = ram_f({2'd1, v[8:4], c[6:0]}, mseed);
                chk("R6 rom_addr", 32'(rom_addr), 32'({e_attr[7:3], e_code, v[3:0]}));
            end
        end else begin
            chk("R4 ram_addr idle", 32'(ram_addr), 32'd0);
            chk("R6 rom_addr idle", 32'(rom_addr), 32'd0);
        end
        if (!e_blank) begin
            c = k - 2;
            e_code  = ram_f({2'd0, v[8:4], c[6:0]}, mseed);
            e_attr  = ram_f({2'd1, v[8:4], c[6:0]}, mseed);
            e_color = ram_f({2'd2, v[8:4], c[6:0]}, mseed);
            chk("R7 glyph", 32'(glyph), 32'(rom_f({e_attr[7:3], e_code, v[3:0]}, mseed)));
            chk("R7 color", 32'(color), 32'(e_color));
            chk("R7 attr", 32'(attr), 32'(e_attr));
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) edges++;
        else       edges = 0;
        #1;
        check_cycle();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        int n;
        mseed = 8'($urandom(32'd2024));
        rst_n = 1'b0;
        repeat (4) step();
        rst_n = 1'b1;
        // full frame plus wrap into the next one (R1, R2 wrap points)
        repeat (VT * HT + 3 * HT) step();
        // reset at a random point inside a line (R8)
        n = 2000 + int'($urandom % 3000);
        repeat (n) step();
        rst_n = 1'b0;
        n = 3 + int'($urandom % 4);
        repeat (n) step();
        rst_n = 1'b1;
        repeat (25 * HT) step();
        summary();
        $finish;
    end

    initial begin
        #1900000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end
endmodule